// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer built around an 8-bit up-counter. The counter advances on ticks from a prescaler whose division ratio is one of eight powers of two, from 32 up to 4096 input clocks. Software reaches two registers through 16-bit write strobes: one for the counter and one for the control/status register. Each register also has an 8-bit readback port.

A write is honoured only when the upper byte of the write word holds that register's own key. Any other upper byte leaves every register untouched and latches a sticky key-error output, so a stray or mis-aimed bus write cannot reload or stop the watchdog. When the counter rolls over from its all-ones value, the block sets an overflow flag in the control register and emits a single-cycle pulse that a reset or interrupt stage downstream can consume.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rstN` is low and after its release, the counter reads 0x00, the control register reads 0x00 (clock select 0, divide by 32, timer stopped), and `ovfPulse` and `keyErr` are 0.
- R2: A counter write with `wrData[15:8]` = 0x5A loads `wrData[7:0]` into the counter, visible on `cntRd` one cycle later. It also clears the prescaler, so the next increment comes exactly one full divide period after the write edge.
- R3: A control write with `wrData[15:8]` = 0xA5 loads `wrData[6:0]` into control bits 6:0, visible on `csrRd` one cycle later.
- R4: A write whose upper byte differs from its register's key (0x5A for the counter, 0xA5 for the control register) changes neither the counter nor the control register. It sets `keyErr`, which then stays at 1 until reset.
- R5: While control bit 5 (run enable) is 1, the counter increments once every 32 << S input cycles, where S is control bits 2:0. The first increment comes one full period after the write that set bit 5.
- R6: While control bit 5 is 0, the counter holds its value and the prescaler is held at zero.
- R7: When the counter wraps from 0xFF to 0x00, control bit 7 (overflow flag) becomes 1 and `ovfPulse` is high for exactly the one cycle in which `cntRd` first reads 0x00.
- R8: Software cannot set the overflow flag. A keyed control write with bit 7 = 0 clears it, and a keyed control write with bit 7 = 1 leaves it unchanged. If a wrap and a clearing write fall in the same cycle, the wrap wins.
- R9: A change of the clock-select field while the timer runs leaves the counter value untouched. The old ratio finishes the current prescaler period, and the new ratio applies from the following period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; also the prescaler source |
| rstN | input | 1 | Active-low synchronous reset |
| cntWrEn | input | 1 | Write strobe for the counter |
| csrWrEn | input | 1 | Write strobe for the control/status register |
| wrData | input | 16 | Write word: key in bits 15:8, payload in bits 7:0 |
| cntRd | output | 8 | Current counter value |
| csrRd | output | 8 | Control/status: bit 7 overflow flag, bit 5 run enable, bits 2:0 clock select, bits 6, 4, 3 plain storage |
| ovfPulse | output | 1 | One-cycle pulse on counter wrap |
| keyErr | output | 1 | Sticky flag for a write with a wrong key |

## Verification
Register writes become visible one cycle after the write edge. A counter increment is due exactly 32 << S cycles after the last prescaler restart, which is the enabling control write, a counter write or the previous tick. The overflow pulse and flag appear in the same cycle that the counter first reads zero. The bench drives every write right after a falling edge, so the write edge is the next rising edge, and it counts falling edges from there. Each timed check samples once one cycle before the due edge to confirm the old value and once just after it to confirm the new one.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int CNT_W      = 8;
  localparam int KEY_W      = 8;
  localparam int WR_W       = KEY_W + CNT_W;
  localparam int NUM_SEL    = 8;
  localparam int SEL_W      = $clog2(NUM_SEL);
  localparam int BASE_SHIFT = 5;
  localparam int PRE_W      = BASE_SHIFT + NUM_SEL - 1;

  localparam logic [KEY_W-1:0] CNT_KEY = 8'h5A;
  localparam logic [KEY_W-1:0] CSR_KEY = 8'hA5;

  localparam int FLAG_BIT = 7;
  localparam int RUN_BIT  = 5;
  localparam int SEL_LSB  = 0;

  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] cntVal;
    logic             runEn;
    logic [SEL_W-1:0] selPend;
  } ctrlStrobe_t;
endpackage

// File: rtl/keyed_wdt_ctrl.sv
module keyed_wdt_ctrl
  import keyed_wdt_pkg::*;
#(
  parameter logic [KEY_W-1:0] CntKey = CNT_KEY,
  parameter logic [KEY_W-1:0] CsrKey = CSR_KEY
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntWrEn,
  input  logic              csrWrEn,
  input  logic [WR_W-1:0]   wrData,
  input  logic              wrapEvt,
  output ctrlStrobe_t       strobe,
  output logic [CNT_W-1:0]  csrQ,
  output logic              keyErr
);
  logic [KEY_W-1:0] keyField;
  logic [CNT_W-1:0] payload;
  logic             cntKeyOk;
  logic             csrKeyOk;
  logic             badWrite;
  logic [CNT_W-1:0] csrNext;
  logic             flagNext;

  assign keyField = wrData[WR_W-1:CNT_W];
  assign payload  = wrData[CNT_W-1:0];

  assign cntKeyOk = cntWrEn && (keyField == CntKey);
  assign csrKeyOk = csrWrEn && (keyField == CsrKey);
  assign badWrite = (cntWrEn && !cntKeyOk) || (csrWrEn && !csrKeyOk);

  // overflow flag: hardware set dominates, software may only clear
  always_comb begin
    flagNext = csrQ[FLAG_BIT];
    if (csrKeyOk) flagNext = csrQ[FLAG_BIT] & payload[FLAG_BIT];
    if (wrapEvt)  flagNext = 1'b1;
  end

  always_comb begin
    csrNext = csrQ;
    if (csrKeyOk) csrNext = payload;
    csrNext[FLAG_BIT] = flagNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrQ   <= '0;
      keyErr <= 1'b0;
    end else begin
      csrQ <= csrNext;
      if (badWrite) keyErr <= 1'b1;
    end
  end

  // select value the register will hold after this edge, built without wrapEvt
  always_comb begin
    strobe.cntLoad = cntKeyOk;
    strobe.cntVal  = payload;
    strobe.runEn   = csrQ[RUN_BIT];
    strobe.selPend = csrKeyOk ? payload[SEL_LSB +: SEL_W] : csrQ[SEL_LSB +: SEL_W];
  end
endmodule

// File: rtl/keyed_wdt_datapath.sv
module keyed_wdt_datapath
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic             wrapEvt,
  output logic [CNT_W-1:0] cntQ,
  output logic             ovfPulse
);
  logic [PRE_W-1:0]   preCnt;
  logic [SEL_W-1:0]   activeSel;
  logic [NUM_SEL-1:0] isTerm;
  logic               tick;
  logic               reloadSel;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
    localparam logic [PRE_W-1:0] LIMIT = PRE_W'((32'd1 << (BASE_SHIFT + g)) - 32'd1);
    assign isTerm[g] = (preCnt == LIMIT);
  end

  assign tick      = strobe.runEn && isTerm[activeSel];
  assign wrapEvt   = tick && !strobe.cntLoad && (cntQ == {CNT_W{1'b1}});
  assign reloadSel = !strobe.runEn || strobe.cntLoad || tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt    <= '0;
      activeSel <= '0;
    end else begin
      if (!strobe.runEn || strobe.cntLoad || tick) preCnt <= '0;
      else                                           preCnt <= preCnt + PRE_W'(1);
      if (reloadSel) activeSel <= strobe.selPend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ     <= '0;
      ovfPulse <= 1'b0;
    end else begin
      if (strobe.cntLoad) cntQ <= strobe.cntVal;
      else if (tick)      cntQ <= cntQ + CNT_W'(1);
      ovfPulse <= wrapEvt;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_wdt_pkg::*;
#(
  parameter logic [KEY_W-1:0] CntKey = CNT_KEY,
  parameter logic [KEY_W-1:0] CsrKey = CSR_KEY
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntWrEn,
  input  logic             csrWrEn,
  input  logic [WR_W-1:0]  wrData,
  output logic [CNT_W-1:0] cntRd,
  output logic [CNT_W-1:0] csrRd,
  output logic             ovfPulse,
  output logic             keyErr
);
  ctrlStrobe_t strobe;
  logic        wrapEvt;

  keyed_wdt_ctrl #(.CntKey(CntKey), .CsrKey(CsrKey)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntWrEn (cntWrEn),
    .csrWrEn (csrWrEn),
    .wrData  (wrData),
    .wrapEvt (wrapEvt),
    .strobe  (strobe),
    .csrQ    (csrRd),
    .keyErr  (keyErr)
  );

  keyed_wdt_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrapEvt  (wrapEvt),
    .cntQ     (cntRd),
    .ovfPulse (ovfPulse)
  );
endmodule

// File: rtl/keyed_wdt_checker.sv
module keyed_wdt_checker
  import keyed_wdt_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cntWrEn,
  input logic             csrWrEn,
  input logic [WR_W-1:0]  wrData,
  input logic [CNT_W-1:0] cntRd,
  input logic [CNT_W-1:0] csrRd,
  input logic             ovfPulse,
  input logic             keyErr
);
  // R2
  a_r2_keyed_cnt_load: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && wrData[WR_W-1:CNT_W] == CNT_KEY) |=> (cntRd == $past(wrData[CNT_W-1:0])));

  // R4
  a_r4_bad_key_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrEn && wrData[WR_W-1:CNT_W] != CNT_KEY && !csrWrEn && !csrRd[RUN_BIT])
      |=> ($stable(cntRd) && $stable(csrRd) && keyErr));

  // R4
  a_r4_key_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    keyErr |=> keyErr);

  // R6
  a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!csrRd[RUN_BIT] && !cntWrEn) |=> $stable(cntRd));

  // R7
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> !ovfPulse);

  // R7
  a_r7_pulse_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (cntRd == '0 && csrRd[FLAG_BIT]));

  // R8
  a_r8_flag_only_by_wrap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csrRd[FLAG_BIT]) |-> ovfPulse);
endmodule

bind keyed_watchdog keyed_wdt_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cntWrEn  (cntWrEn),
  .csrWrEn  (csrWrEn),
  .wrData   (wrData),
  .cntRd    (cntRd),
  .csrRd    (csrRd),
  .ovfPulse (ovfPulse),
  .keyErr   (keyErr)
);

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntWrEn = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [7:0]  cntRd;
  logic [7:0]  csrRd;
  logic        ovfPulse;
  logic        keyErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  keyed_watchdog dut (
    .clk(clk), .rstN(rstN), .cntWrEn(cntWrEn), .csrWrEn(csrWrEn),
    .wrData(wrData), .cntRd(cntRd), .csrRd(csrRd),
    .ovfPulse(ovfPulse), .keyErr(keyErr)
  );

  // vector: {isCsr, write word, expected cnt, expected csr, expected keyErr}; timer stopped
  localparam int NVEC = 9;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 16'h5A3C, 8'h3C, 8'h00, 1'b0},  // R2
    {1'b1, 16'hA506, 8'h3C, 8'h06, 1'b0},  // R3
    {1'b0, 16'h5AC3, 8'hC3, 8'h06, 1'b0},  // R2
    {1'b1, 16'hA55A, 8'hC3, 8'h5A, 1'b0},  // R3 storage bits
    {1'b1, 16'hA583, 8'hC3, 8'h03, 1'b0},  // R8 software cannot set flag
    {1'b0, 16'hA577, 8'hC3, 8'h03, 1'b1},  // R4 wrong key on counter
    {1'b1, 16'h5A11, 8'hC3, 8'h03, 1'b1},  // R4 wrong key on control
    {1'b0, 16'h0000, 8'hC3, 8'h03, 1'b1},  // R4 zero key
    {1'b0, 16'h5A00, 8'h00, 8'h03, 1'b1}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // call at a falling edge; the write edge is the next rising edge
  task automatic doWrite(input bit isCsr, input logic [15:0] d);
    cntWrEn = !isCsr;
    csrWrEn = isCsr;
    wrData  = d;
    @(negedge clk);
    cntWrEn = 1'b0;
    csrWrEn = 1'b0;
    wrData  = '0;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    waitN(3);
    check("R1 cnt", {24'h0, cntRd}, 32'h00);
    check("R1 csr", {24'h0, csrRd}, 32'h00);
    check("R1 pulse/err", {30'h0, ovfPulse, keyErr}, 32'h0);
    rstN = 1'b1;
    waitN(1);
    check("R1 after release", {15'h0, cntRd, csrRd, keyErr}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      doWrite(VEC[v][33], VEC[v][32:17]);
      check($sformatf("R2/R3/R4 vector %0d", v),
            {15'h0, cntRd, csrRd, keyErr}, {15'h0, VEC[v][16:0]});
    end

    // R5: divide by 32 from the enabling write
    doWrite(1'b1, 16'hA520);
    waitN(31); check("R5 div32 before first tick", {24'h0, cntRd}, 32'h00);
    waitN(1);  check("R5 div32 first tick", {24'h0, cntRd}, 32'h01);
    waitN(31); check("R5 div32 before second tick", {24'h0, cntRd}, 32'h01);
    waitN(1);  check("R5 div32 second tick", {24'h0, cntRd}, 32'h02);

    // R2: counter write restarts the prescaler
    waitN(10);
    doWrite(1'b0, 16'h5A10);
    waitN(31); check("R2 restart before tick", {24'h0, cntRd}, 32'h10);
    waitN(1);  check("R2 restart tick", {24'h0, cntRd}, 32'h11);

    // R9: select change mid period, applies from the next period
    doWrite(1'b0, 16'h5A40);
    waitN(10);
    doWrite(1'b1, 16'hA521);
    check("R9 counter undisturbed", {24'h0, cntRd}, 32'h40);
    waitN(20); check("R9 old ratio before tick", {24'h0, cntRd}, 32'h40);
    waitN(1);  check("R9 old ratio completes", {24'h0, cntRd}, 32'h41);
    waitN(63); check("R9 R5 div64 before tick", {24'h0, cntRd}, 32'h41);
    waitN(1);  check("R9 R5 div64 tick", {24'h0, cntRd}, 32'h42);

    // R6: stopped timer holds
    doWrite(1'b1, 16'hA501);
    waitN(200);
    check("R6 stopped holds", {16'h0, cntRd, csrRd}, {16'h0, 8'h42, 8'h01});

    // R7: overflow at divide by 4096
    doWrite(1'b1, 16'hA527);
    doWrite(1'b0, 16'h5AFF);
    waitN(4095);
    check("R7 before wrap", {23'h0, ovfPulse, cntRd}, {23'h0, 1'b0, 8'hFF});
    waitN(1);
    check("R7 wrap pulse", {15'h0, ovfPulse, cntRd, csrRd}, {15'h0, 1'b1, 8'h00, 8'hA7});
    waitN(1);
    check("R7 pulse one cycle", {23'h0, ovfPulse, csrRd}, {23'h0, 1'b0, 8'hA7});

    // R8: flag clearing rules
    doWrite(1'b1, 16'hA5A7);
    check("R8 write one keeps flag", {24'h0, csrRd}, 32'hA7);
    doWrite(1'b1, 16'h5A27);
    check("R8 R4 bad key keeps flag", {24'h0, csrRd}, 32'hA7);
    doWrite(1'b1, 16'hA527);
    check("R8 write zero clears flag", {24'h0, csrRd}, 32'h27);
    doWrite(1'b1, 16'hA500);
    check("R4 key error still sticky", {31'h0, keyErr}, 32'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule